// File: doc/BRIEF.md
# Slot-Time Backoff Countdown Timer

This block is the retry delay counter of a carrier-sense, collision-detect link transmitter. After a collision, the collision-resolution logic loads a backoff count. The timer then counts that value down by one on each slot-time tick. A tick is a single-cycle strobe from a slot-time prescaler elsewhere in the chip, not the system clock. When the count is used up, the timer raises a one-cycle expiry pulse and the transmitter may try again.

The timer has two start policies, chosen by a mode input that is sampled with each load. In normal mode the countdown begins at once. In alternate mode the timer holds its loaded value until it sees that the interframe space has ended, and only then starts counting. This keeps the backoff window from expiring while the line is still quiet by rule. The count is visible on a read-only output, and nothing but a load or a counted tick can change it. The random backoff value comes from outside the block.

Top module: `bo_timer`

## Requirements
- R1: After reset, count_o is 0, busy_o is 0 and expire_o is 0.
- R2: In the cycle after load_i is sampled high, count_o equals the sampled load_val_i and busy_o is 1.
- R3: In normal mode (alt_mode_i sampled low at load), each slot_tick_i sampled while counting lowers count_o by one in the next cycle. With no tick and no load, count_o holds.
- R4: A tick sampled while counting with count_o equal to 1 sets count_o to 0, drops busy_o and raises expire_o for exactly one cycle. A load of N≥1 therefore expires on its Nth counted tick.
- R5: A load value of 0 expires on the first counted tick, with the same outputs as R4 and no wrap of the count.
- R6: In alternate mode (alt_mode_i sampled high at load), ticks are ignored and count_o holds with busy_o high until ifs_done_i is sampled high. Only ticks at later clock edges count.
- R7: A load while busy restarts the timer with the new value and the newly sampled mode. A load in the same cycle as a tick takes priority, and that tick is not counted.
- R8: While idle, ticks and ifs_done_i have no effect: count_o stays as it was and expire_o stays 0.
- R9: Changing alt_mode_i after a load does not alter the running or waiting timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_tick_i | input | 1 | One-cycle strobe per slot time |
| load_i | input | 1 | Load strobe; starts or restarts the backoff |
| load_val_i | input | W (8) | Backoff count in slot times |
| alt_mode_i | input | 1 | 1: defer countdown until interframe space ends (sampled at load) |
| ifs_done_i | input | 1 | Interframe space has ended (level) |
| count_o | output | W (8) | Current remaining count |
| busy_o | output | 1 | High from load until expiry, including the deferral wait |
| expire_o | output | 1 | One-cycle pulse when the backoff ends |

## Verification
Every output is registered, so every result of a load, a tick or an interframe-space indication appears in the cycle after the edge that sampled it. The expiry pulse lasts only that one cycle. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. It advances its reference model exactly once per rising edge, so each comparison lines up with the single-edge latency. Deferred starts add one edge for the wait to clear before any tick counts, and the bench model includes that extra edge.

// File: rtl/bo_pkg.sv
package bo_pkg;
  typedef enum logic [1:0] {
    BO_IDLE = 2'd0,
    BO_WAIT = 2'd1,
    BO_RUN  = 2'd2
  } bo_state_e;
endpackage

// File: rtl/bo_counter.sv
module bo_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] count_q;

  // zero and one both finish on the next counted tick
  assign last_o  = (count_q <= ONE);
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (dec_i)  count_q <= last_o ? '0 : count_q - ONE;
  end
endmodule

// File: rtl/bo_fsm.sv
module bo_fsm
  import bo_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic      alt_mode_i,
  input  logic      ifs_done_i,
  input  logic      slot_tick_i,
  input  logic      cnt_last_i,
  output bo_state_e state_o,
  output logic      dec_o,
  output logic      expire_o
);
  bo_state_e state_q, state_d;
  logic      expire_q;
  logic      finish;

  assign dec_o  = (state_q == BO_RUN) && slot_tick_i && !load_i;
  assign finish = dec_o && cnt_last_i;

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = alt_mode_i ? BO_WAIT : BO_RUN;
    end else begin
      unique case (state_q)
        BO_WAIT: if (ifs_done_i) state_d = BO_RUN;
        BO_RUN:  if (finish)     state_d = BO_IDLE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= BO_IDLE;
      expire_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      expire_q <= finish;
    end
  end

  assign state_o  = state_q;
  assign expire_o = expire_q;
endmodule

// File: rtl/bo_timer.sv
module bo_timer
  import bo_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         slot_tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         alt_mode_i,
  input  logic         ifs_done_i,
  output logic [W-1:0] count_o,
  output logic         busy_o,
  output logic         expire_o
);
  bo_state_e state;
  logic      dec;
  logic      last;

  bo_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .alt_mode_i  (alt_mode_i),
    .ifs_done_i  (ifs_done_i),
    .slot_tick_i (slot_tick_i),
    .cnt_last_i  (last),
    .state_o     (state),
    .dec_o       (dec),
    .expire_o    (expire_o)
  );

  bo_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .dec_i      (dec),
    .count_o    (count_o),
    .last_o     (last)
  );

  assign busy_o = (state != BO_IDLE);
endmodule

// File: rtl/bo_timer_chk.sv
module bo_timer_chk
  import bo_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         slot_tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] count_o,
  input  logic         busy_o,
  input  logic         expire_o,
  input  bo_state_e    state_i
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (busy_o && count_o == $past(load_val_i)));

  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == BO_RUN && slot_tick_i && !load_i && count_o > W'(1))
      |=> (count_o == W'($past(count_o) - W'(1)) && busy_o));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !slot_tick_i) |=> $stable(count_o));

  p_expire_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);

  p_expire_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (!busy_o && count_o == '0));

  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == BO_RUN && count_o == '0 && slot_tick_i && !load_i) |=> expire_o);

  p_wait_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == BO_WAIT && !load_i) |=> (busy_o && $stable(count_o) && !expire_o));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load_i) |=> (!expire_o && $stable(count_o) && !busy_o));
endmodule

bind bo_timer bo_timer_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slot_tick_i (slot_tick_i),
  .load_i      (load_i),
  .load_val_i  (load_val_i),
  .count_o     (count_o),
  .busy_o      (busy_o),
  .expire_o    (expire_o),
  .state_i     (state)
);

// File: tb/tb_bo_timer.sv
module tb_bo_timer;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         slot_tick_i = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] load_val_i = '0;
  logic         alt_mode_i = 1'b0;
  logic         ifs_done_i = 1'b0;
  logic [W-1:0] count_o;
  logic         busy_o;
  logic         expire_o;

  int total = 0;
  int bad = 0;

  // reference model: 0 idle, 1 waiting for IFS, 2 counting
  int           m_st = 0;
  logic [W-1:0] m_cnt = '0;
  logic         m_exp = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bo_timer #(.W(W)) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_tick_i (slot_tick_i),
    .load_i      (load_i),
    .load_val_i  (load_val_i),
    .alt_mode_i  (alt_mode_i),
    .ifs_done_i  (ifs_done_i),
    .count_o     (count_o),
    .busy_o      (busy_o),
    .expire_o    (expire_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "count", int'(count_o), int'(m_cnt));
    check(tag, "busy", int'(busy_o), (m_st != 0) ? 1 : 0);
    check(tag, "expire", int'(expire_o), int'(m_exp));
  endtask

  task automatic model(input logic ld, input logic [W-1:0] v, input logic tk,
                       input logic ifs, input logic alt);
    m_exp = 1'b0;
    if (ld) begin
      m_cnt = v;
      m_st  = alt ? 1 : 2;
    end else if (m_st == 1) begin
      if (ifs) m_st = 2;
    end else if (m_st == 2 && tk) begin
      if (m_cnt <= 1) begin
        m_cnt = '0;
        m_st  = 0;
        m_exp = 1'b1;
      end else begin
        m_cnt = m_cnt - 1'b1;
      end
    end
  endtask

  // one clock: drive on falling edge, sample just after rising edge
  task automatic step(input string tag, input logic ld, input logic [W-1:0] v,
                      input logic tk, input logic ifs, input logic alt);
    @(negedge clk_i);
    load_i = ld; load_val_i = v; slot_tick_i = tk; ifs_done_i = ifs; alt_mode_i = alt;
    @(posedge clk_i);
    #1;
    model(ld, v, tk, ifs, alt);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ld, tk, ifs, alt;
    logic [W-1:0] v;
    string tag;
    void'($urandom(32'h5eed_b0ff));
    #(CLK_PERIOD * 3);
    check_all("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // normal mode, load 3, ticks with gaps
    step("R2", 1, 8'd3, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0);
    step("R3", 0, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0);
    step("R4", 0, 0, 1, 0, 0);
    step("R4", 0, 0, 0, 0, 0);
    // idle: ticks and IFS ignored
    step("R8", 0, 0, 1, 1, 0);
    step("R8", 0, 0, 1, 0, 1);
    // zero load
    step("R5", 1, 8'd0, 0, 0, 0);
    step("R5", 0, 0, 1, 0, 0);
    step("R5", 0, 0, 0, 0, 0);
    // full-scale load, then reload while busy
    step("R2", 1, 8'd255, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0);
    step("R7", 1, 8'd2, 1, 0, 0);
    step("R7", 0, 0, 1, 0, 0);
    step("R7", 0, 0, 1, 0, 0);
    // alternate mode: hold until IFS done, mode change ignored
    step("R6", 1, 8'd2, 0, 0, 1);
    step("R6", 0, 0, 1, 0, 1);
    step("R9", 0, 0, 1, 0, 0);
    step("R6", 0, 0, 1, 1, 0);
    step("R6", 0, 0, 1, 0, 0);
    step("R4", 0, 0, 1, 0, 1);
    // alternate mode with zero load
    step("R6", 1, 8'd0, 1, 1, 1);
    step("R6", 0, 0, 1, 1, 0);
    step("R5", 0, 0, 1, 0, 0);
    // reload in normal mode while waiting in alternate mode
    step("R6", 1, 8'd4, 0, 0, 1);
    step("R7", 1, 8'd1, 0, 0, 0);
    step("R4", 0, 0, 1, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      ld  = ($urandom % 16) == 0;
      v   = (($urandom % 4) == 0) ? W'($urandom) : W'($urandom % 6);
      tk  = ($urandom % 3) == 0;
      ifs = ($urandom % 4) == 0;
      alt = $urandom % 2;
      if (ld) tag = "R2";
      else if (m_st == 1) tag = "R6";
      else if (m_st == 2 && tk && m_cnt == 0) tag = "R5";
      else if (m_st == 2 && tk && m_cnt == 1) tag = "R4";
      else if (m_st == 2) tag = "R3";
      else tag = "R8";
      step(tag, ld, v, tk, ifs, alt);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule